// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software progress. It counts strobes from a slow, free-running 1 kHz time base and asks for a system reset when software stops clearing it. The time base is delivered as one-cycle tick enables in the block's own clock domain. In normal mode, the only fault is a missing clear. In window mode, each period starts with a closed phase, and a clear that lands inside it is also a fault. A clear is therefore valid only in the open phase that follows the closed phase.

Both periods come from one doubling table of eleven lengths, from 8 to 8192 ticks. The configuration register can only be written within a short window after an unlock strobe. A fuse-style lock input blocks all writes while it is high. A fault raises the reset request for a fixed number of reference-clock cycles and starts the watchdog over.

Top module: `wdog_win`

## Requirements
- R1: After reset the configuration is all zero (watchdog disabled, both selects 0) and `rst_req_o` is low. The write word is laid out as follows: bit 0 enable, bit 1 window mode, bits 5:2 timeout select, bits 9:6 closed-period select.
- R2: A select value s in 0..10 gives a length of 8·2^s ticks. Any value above 10 gives the same length as 10, which is 8192 ticks.
- R3: In normal mode, the tick that completes the timeout length without a clear causes a fault. A clear restarts the count from zero. A tick in the same cycle as a clear is not counted.
- R4: In window mode, a clear during the closed phase causes a fault in that cycle.
- R5: In window mode, the open phase begins once the closed length of ticks has elapsed. A clear in the open phase starts a new closed phase. If no clear arrives, the fault comes after the closed length plus the timeout length.
- R6: A fault raises `rst_req_o` in the cycle after the fault edge, for exactly PULSE_LEN cycles (default 2).
- R7: After a fault, the count restarts from zero in its starting phase (closed in window mode) and the configuration is kept.
- R8: While the watchdog is disabled, no fault occurs, and clears and ticks have no effect.
- R9: A write is taken only in one of the UNLOCK_WIN cycles (default 4) after the cycle in which `unlock_i` is high. A taken write restarts the count under the new settings.
- R10: A write outside the unlock window is ignored. It leaves both the settings and the running count unchanged.
- R11: While `lock_i` is high, writes are ignored even inside the unlock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe per 1 kHz time-base tick |
| clr_i | input | 1 | Software clear strobe |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 10 | Configuration word (layout in R1) |
| unlock_i | input | 1 | Opens the short write window |
| lock_i | input | 1 | Fuse-style lock; blocks all writes while high |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The vector table runs each mode with no clear, with a clear one tick before a boundary, and with a clear exactly on a boundary. This separates off-by-one errors in the closed-phase end from those in the timeout end. Clears placed before the window opens, inside it, and after timeout separate the early-clear fault from a valid restart and from a late fault. Directed cases target the unlock window edge at UNLOCK_WIN versus UNLOCK_WIN+1 cycles and the ignored-write paths. An ignored write shows up as a fault at the original timeout, which tells a wrongly reset counter apart from a wrongly changed period. The largest select and an out-of-range select show the clamp.

// File: rtl/wdog_win_pkg.sv
package wdog_win_pkg;

  localparam int SEL_W = 4;

  // Configuration word: en at bit 0, win at bit 1, tmo_sel 5:2, closed_sel 9:6
  typedef struct packed {
    logic [SEL_W-1:0] closed_sel;
    logic [SEL_W-1:0] tmo_sel;
    logic             win;
    logic             en;
  } wd_cfg_t;

  localparam int CFG_W = $bits(wd_cfg_t);

  typedef enum logic {
    PH_OPEN   = 1'b0,
    PH_CLOSED = 1'b1
  } wd_phase_t;

  // Clamp a select value to the last table entry
  function automatic int unsigned sel_clamp(input logic [SEL_W-1:0] sel,
                                            input int unsigned n_sel);
    int unsigned s;
    s = 32'(sel);
    return (s >= n_sel) ? (n_sel - 1) : s;
  endfunction

  // Length in ticks: base doubled once per select step
  function automatic int unsigned period_len(input logic [SEL_W-1:0] sel,
                                             input int unsigned base_log2,
                                             input int unsigned n_sel);
    return 32'd1 << (base_log2 + sel_clamp(sel, n_sel));
  endfunction

  function automatic wd_phase_t start_phase(input wd_cfg_t c);
    return c.win ? PH_CLOSED : PH_OPEN;
  endfunction

endpackage

// File: rtl/wdog_win_guard.sv
module wdog_win_guard
  import wdog_win_pkg::*;
#(
  parameter int      UNLOCK_WIN = 4,
  parameter wd_cfg_t RST_CFG    = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlock_i,
  input  logic       lock_i,
  input  logic       wr_en_i,
  input  wd_cfg_t    wr_cfg_i,
  output wd_cfg_t    cfg_o,
  output logic       cfg_load_o,
  output logic       armed_o
);
  localparam int AW = $clog2(UNLOCK_WIN + 1);

  logic [AW-1:0] arm_q;
  wd_cfg_t       cfg_q;
  logic          wr_ok;

  assign armed_o    = (arm_q != '0);
  assign wr_ok      = wr_en_i && armed_o && !lock_i;
  assign cfg_load_o = wr_ok;
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else if (unlock_i) begin
      arm_q <= AW'(UNLOCK_WIN);
    end else if (wr_ok) begin
      arm_q <= '0;            // one write per unlock
    end else if (armed_o) begin
      arm_q <= arm_q - AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= RST_CFG;
    else if (wr_ok) cfg_q <= wr_cfg_i;
  end

endmodule

// File: rtl/wdog_win_core.sv
module wdog_win_core
  import wdog_win_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int N_SEL     = 11,
  parameter int CNT_W     = BASE_LOG2 + N_SEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  wd_cfg_t          cfg_i,
  input  logic             cfg_load_i,
  input  wd_cfg_t          cfg_new_i,
  output logic             fault_o,
  output wd_phase_t        phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, tmo_len, cls_len, limit;
  wd_phase_t        ph_q;
  logic             tick_end, clr_ok, clr_bad, open_evt;

  assign tmo_len = CNT_W'(period_len(cfg_i.tmo_sel,    BASE_LOG2, N_SEL));
  assign cls_len = CNT_W'(period_len(cfg_i.closed_sel, BASE_LOG2, N_SEL));
  assign limit   = (ph_q == PH_CLOSED) ? cls_len : tmo_len;

  assign tick_end = cfg_i.en && tick_i && ((cnt_q + CNT_W'(1)) == limit);
  assign clr_ok   = cfg_i.en && clr_i && (ph_q == PH_OPEN);
  assign clr_bad  = cfg_i.en && clr_i && (ph_q == PH_CLOSED);
  assign open_evt = tick_end && (ph_q == PH_CLOSED) && !clr_i;
  // a clear beats a tick in the same cycle
  assign fault_o  = clr_bad || (tick_end && (ph_q == PH_OPEN) && !clr_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_OPEN;
    end else if (cfg_load_i) begin
      cnt_q <= '0;
      ph_q  <= start_phase(cfg_new_i);
    end else if (!cfg_i.en || fault_o || clr_ok) begin
      cnt_q <= '0;
      ph_q  <= start_phase(cfg_i);
    end else if (open_evt) begin
      cnt_q <= '0;
      ph_q  <= PH_OPEN;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/wdog_win_pulse.sv
module wdog_win_pulse #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire_i)         left_q <= PW'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign pulse_o = (left_q != '0);

endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_win_pkg::*;
#(
  parameter int      BASE_LOG2  = 3,
  parameter int      N_SEL      = 11,
  parameter int      PULSE_LEN  = 2,
  parameter int      UNLOCK_WIN = 4,
  parameter wd_cfg_t RST_CFG    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             unlock_i,
  input  logic             lock_i,
  output logic             rst_req_o
);
  localparam int CNT_W = BASE_LOG2 + N_SEL;

  wd_cfg_t          cfg_q;
  wd_cfg_t          cfg_new;
  logic             cfg_load;
  logic             wr_armed;
  logic             fault_evt;
  wd_phase_t        ph;
  logic [CNT_W-1:0] cnt;

  assign cfg_new = wd_cfg_t'(wr_data_i);

  wdog_win_guard #(
    .UNLOCK_WIN (UNLOCK_WIN),
    .RST_CFG    (RST_CFG)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .unlock_i   (unlock_i),
    .lock_i     (lock_i),
    .wr_en_i    (wr_en_i),
    .wr_cfg_i   (cfg_new),
    .cfg_o      (cfg_q),
    .cfg_load_o (cfg_load),
    .armed_o    (wr_armed)
  );

  wdog_win_core #(
    .BASE_LOG2 (BASE_LOG2),
    .N_SEL     (N_SEL),
    .CNT_W     (CNT_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .clr_i      (clr_i),
    .cfg_i      (cfg_q),
    .cfg_load_i (cfg_load),
    .cfg_new_i  (cfg_new),
    .fault_o    (fault_evt),
    .phase_o    (ph),
    .cnt_o      (cnt)
  );

  wdog_win_pulse #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fault_evt),
    .pulse_o (rst_req_o)
  );

endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk
  import wdog_win_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int N_SEL     = 11,
  parameter int PULSE_LEN = 2,
  parameter int CNT_W     = BASE_LOG2 + N_SEL
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             wr_en_i,
  input logic             lock_i,
  input logic             rst_req_o,
  input logic [CFG_W-1:0] cfg,
  input logic             armed,
  input logic             phase,
  input logic [CNT_W-1:0] cnt,
  input logic             fault_evt,
  input logic             cfg_load
);
  wd_cfg_t c;
  assign c = wd_cfg_t'(cfg);

  // cycles since the last fault, saturating
  localparam int SW = $clog2(PULSE_LEN + 2);
  localparam logic [SW-1:0] SMAX = SW'(PULSE_LEN + 1);
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= SMAX;
    else if (fault_evt)      since_q <= '0;
    else if (since_q != SMAX) since_q <= since_q + SW'(1);
  end

  logic [CNT_W:0] lim_now;
  assign lim_now = (CNT_W+1)'(1) << (BASE_LOG2 +
                   ((phase ? 32'(c.closed_sel) : 32'(c.tmo_sel)) >= N_SEL ? N_SEL - 1 :
                    (phase ? 32'(c.closed_sel) : 32'(c.tmo_sel))));

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> rst_req_o);
  p_pulse_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (since_q < SW'(PULSE_LEN)));
  p_pulse_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_o |-> (since_q >= SW'(PULSE_LEN)));
  p_early_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && c.en && phase && !cfg_load) |=> rst_req_o);
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !c.en |-> !fault_evt);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c.en |-> ({1'b0, cnt} < lim_now));
  p_clr_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && c.en && !phase && !cfg_load) |=> (cnt == '0));
  p_no_unlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !armed) |=> $stable(cfg));
  p_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(cfg));

endmodule

bind wdog_win wdog_win_chk #(
  .BASE_LOG2 (BASE_LOG2),
  .N_SEL     (N_SEL),
  .PULSE_LEN (PULSE_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .wr_en_i   (wr_en_i),
  .lock_i    (lock_i),
  .rst_req_o (rst_req_o),
  .cfg       (cfg_q),
  .armed     (wr_armed),
  .phase     (ph),
  .cnt       (cnt),
  .fault_evt (fault_evt),
  .cfg_load  (cfg_load)
);

// File: tb/sim_wdog_win.sv
`timescale 1ns/1ps
module sim_wdog_win;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, clr_i = 1'b0, wr_en_i = 1'b0, unlock_i = 1'b0, lock_i = 1'b0;
  logic [9:0] wr_data_i = '0;
  logic       rst_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_win u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(clr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .unlock_i(unlock_i),
    .lock_i(lock_i), .rst_req_o(rst_req_o)
  );

  typedef struct packed {
    logic        win;
    logic [3:0]  per;
    logic [3:0]  cls;
    logic [15:0] clr_at;   // 0: no clear
    logic [15:0] exp_at;   // tick count at which the fault shows
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 4'd0, 16'd0,  16'd8},   // R3
    '{1'b0, 4'd2, 4'd0, 16'd0,  16'd32},  // R2
    '{1'b0, 4'd1, 4'd0, 16'd10, 16'd26},  // R3
    '{1'b0, 4'd0, 4'd0, 16'd7,  16'd15},  // R3
    '{1'b0, 4'd0, 4'd0, 16'd8,  16'd8},   // R3
    '{1'b1, 4'd0, 4'd1, 16'd0,  16'd24},  // R5
    '{1'b1, 4'd0, 4'd0, 16'd5,  16'd5},   // R4
    '{1'b1, 4'd0, 4'd0, 16'd7,  16'd7},   // R4
    '{1'b1, 4'd0, 4'd0, 16'd8,  16'd24},  // R5
    '{1'b1, 4'd0, 4'd0, 16'd15, 16'd31},  // R5
    '{1'b1, 4'd1, 4'd0, 16'd16, 16'd40}   // R5
  };

  function automatic logic [9:0] mk(input bit en, input bit win,
                                    input logic [3:0] per, input logic [3:0] cls);
    return {cls, per, win, en};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle with the given strobes; returns at the next falling edge
  task automatic cyc(input bit t, input bit c, input bit w, input logic [9:0] d, input bit u);
    tick_i = t; clr_i = c; wr_en_i = w; wr_data_i = d; unlock_i = u;
    @(negedge clk);
    tick_i = 0; clr_i = 0; wr_en_i = 0; unlock_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0);
  endtask

  task automatic configure(input logic [9:0] d);
    cyc(0, 0, 0, '0, 1);
    cyc(0, 0, 1, d, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, '0, 0);
  endtask

  task automatic run_until_fault(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      cyc(1, 0, 0, '0, 0);
      if (rst_req_o) begin n = i; return; end
    end
  endtask

  // counts the high cycles of a pulse already seen high, returns after it ends
  task automatic pulse_width(output int w);
    w = 1;
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, '0, 0);
      if (!rst_req_o) return;
      w++;
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int got, w;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(rst_req_o == 1'b0, "R1 reset request low", rst_req_o, 0);
    // R8 / R1: disabled by default, ticks and clears do nothing
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1, i % 3 == 0, 0, '0, 0);
      if (rst_req_o) seen = 1;
    end
    check(!seen, "R8 disabled never faults", seen, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      configure(mk(1, VECS[v].win, VECS[v].per, VECS[v].cls));
      got = 0;
      for (int t = 1; t <= 300; t++) begin
        cyc(1, 0, 0, '0, 0);
        if (rst_req_o) begin got = t; break; end
        if (t == int'(VECS[v].clr_at)) begin
          cyc(0, 1, 0, '0, 0);
          if (rst_req_o) begin got = t; break; end
        end
      end
      check(got == int'(VECS[v].exp_at), VECS[v].win ? "R4/R5 window fault tick" : "R3 normal fault tick",
            got, int'(VECS[v].exp_at));
      if (got != 0) begin
        pulse_width(w);
        check(w == 2, "R6 pulse width", w, 2);
      end
      idle(2);
    end

    // R2: largest entry and clamp of an out-of-range select
    configure(mk(1, 0, 4'd10, 4'd0));
    run_until_fault(9000, got);
    check(got == 8192, "R2 select 10", got, 8192);
    idle(3);
    configure(mk(1, 0, 4'd15, 4'd0));
    run_until_fault(9000, got);
    check(got == 8192, "R2 select clamp", got, 8192);
    idle(3);

    // R7: count restarts after a fault, normal mode
    configure(mk(1, 0, 4'd0, 4'd0));
    run_until_fault(20, got);
    idle(3);
    run_until_fault(20, got);
    check(got == 8, "R7 restart after fault", got, 8);
    idle(3);

    // R7: window mode restarts in the closed phase
    configure(mk(1, 1, 4'd0, 4'd0));
    ticks(2);
    cyc(0, 1, 0, '0, 0);
    idle(3);
    ticks(6);
    cyc(0, 1, 0, '0, 0);
    check(rst_req_o == 1'b1, "R7 closed phase after fault", rst_req_o, 1);
    idle(3);

    // R3: clear and tick in the same cycle, the tick is not counted
    configure(mk(1, 0, 4'd0, 4'd0));
    ticks(7);
    cyc(1, 1, 0, '0, 0);
    check(rst_req_o == 1'b0, "R3 clear wins over tick", rst_req_o, 0);
    run_until_fault(20, got);
    check(got == 8, "R3 count after combined clear", got, 8);
    idle(3);

    // R10: write without unlock ignored, count kept
    configure(mk(1, 0, 4'd0, 4'd0));
    ticks(4);
    cyc(0, 0, 1, mk(1, 0, 4'd3, 4'd0), 0);
    run_until_fault(100, got);
    check(got == 4, "R10 write without unlock ignored", got, 4);
    idle(3);

    // R11: lock blocks an unlocked write
    configure(mk(1, 0, 4'd0, 4'd0));
    ticks(4);
    lock_i = 1'b1;
    cyc(0, 0, 0, '0, 1);
    cyc(0, 0, 1, mk(1, 0, 4'd3, 4'd0), 0);
    lock_i = 1'b0;
    run_until_fault(100, got);
    check(got == 4, "R11 locked write ignored", got, 4);
    idle(3);

    // R9: unlock window edge, too late
    configure(mk(1, 0, 4'd0, 4'd0));
    ticks(2);
    cyc(0, 0, 0, '0, 1);
    idle(4);
    cyc(0, 0, 1, mk(1, 0, 4'd3, 4'd0), 0);
    run_until_fault(100, got);
    check(got == 6, "R9 write after window closes", got, 6);
    idle(3);

    // R9: last cycle of the window, taken and restarts
    configure(mk(1, 0, 4'd0, 4'd0));
    ticks(2);
    cyc(0, 0, 0, '0, 1);
    idle(3);
    cyc(0, 0, 1, mk(1, 0, 4'd1, 4'd0), 0);
    run_until_fault(100, got);
    check(got == 16, "R9 write in last window cycle", got, 16);
    idle(3);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule